// File: doc/BRIEF.md
# Real-Time Counter Control Register with Cross-Domain Command Handshakes

This block is the bus-facing control and status register of a real-time counter whose timekeeping logic runs on its own slow clock. Software writes one-hot command bits into a single control word: start, stop, alarm enable, alarm disable, time upload, time clear-and-upload, time download, wakeup set, wakeup clear and update-flag clear. It reads back status bits that show both the state that was asked for and whether the request has reached the counter domain yet.

Commands that need the counter domain travel over toggle request/acknowledge channels. Each channel has a two-flop synchronizer in each direction. A command stays pending, and reads back as such, until the acknowledge toggle returns. Download, update-flag clear and the wakeup bits act in the bus domain on the clock edge of the write. The block also holds the prescaler register, which takes writes only while the counter is stopped, and a staging word used for time uploads and downloads. Two events from the counter domain, one advance tick and one wake event, are brought across as single bus-cycle pulses.

Address map (word addresses on `bus_addr`): 0 is the control word, 1 is the prescaler, 2 is the staging word, and 3 is unused and reads 0.

Top module: `rtc_ctrl_regs`

## Requirements
- R1: After reset the control word reads 0, the prescaler reads PRESC_RST (default 16'h7FFF), the staging word reads 0, and `cnt_run`, `cnt_alarm_en` and `wakeup_o` are 0.
- R2: Writing 1 to control bit 0 (start) makes bit 0 (running) read 1 from the next cycle on, and `cnt_run` rises later. Writing 1 to bit 1 (stop) keeps bit 0 reading 1 until the counter domain has dropped `cnt_run` and acknowledged; only then does bit 0 read 0.
- R3: A write to the prescaler (address 1, low PRESC_W bits) takes effect only while bit 0 reads 0. A write made while bit 0 reads 1 leaves the prescaler unchanged.
- R4: Writing 1 to bit 5 (upload) copies the staging word to the counter domain, where it appears on `cnt_load_val` with a one-cycle `cnt_load_stb`. Bit 5 reads 1 from the next cycle until the transfer is acknowledged.
- R5: Writing 1 to bit 4 (clear) sets the staging word to 0 and uploads 0. Bit 5 reads 1 while that transfer is pending.
- R6: Writing 1 to bit 6 (download) loads `cnt_value` into the staging word on the same clock edge, with no handshake.
- R7: Writing 1 to bit 2 (alarm on) makes bit 2 (alarm enabled) read 1 on the next cycle. Writing 1 to bit 3 (alarm off) keeps bit 2 at 1 until the disable has reached `cnt_alarm_en` and been acknowledged.
- R8: Bit 10 (updated) is set by every `cnt_tick` pulse. Writing 1 to it clears it. A tick that arrives in the same cycle as the clear wins.
- R9: Writing 1 to bit 9 sets bit 8 (wake) and `wakeup_o`, and so does a `cnt_wake` pulse. Writing 1 to bit 8 clears them. A set wins over a clear in the same cycle.
- R10: A command to the run channel (bits 0/1), the alarm channel (bits 2/3) or the upload channel (bits 4/5) is ignored while that channel is still pending.
- R11: Writing 0 to a command bit has no effect. Control bits 1, 3, 4, 6, 7, 9 and 11 to 31 read 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_addr | input | 2 | Word address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| prescale_o | output | PRESC_W | Prescaler value to the counter |
| wakeup_o | output | 1 | Wakeup output, equal to the wake status |
| cnt_clk | input | 1 | Counter-domain clock |
| cnt_rst | input | 1 | Synchronous active-high reset, counter domain |
| cnt_value | input | TIME_W | Current counter value, read for download |
| cnt_tick | input | 1 | One-cycle pulse in the counter domain on each advance |
| cnt_wake | input | 1 | One-cycle pulse in the counter domain on a wake event |
| cnt_run | output | 1 | Run enable in the counter domain |
| cnt_alarm_en | output | 1 | Alarm enable in the counter domain |
| cnt_load_stb | output | 1 | One-cycle load strobe in the counter domain |
| cnt_load_val | output | TIME_W | Value to load, valid with `cnt_load_stb` |

## Verification
The bench goes after the pending windows. It checks that a stop or an alarm-off still reads 1 right after the write and while the counter-domain output is still high. A design that cleared the status at once would let software rewrite the prescaler while the counter is still running. A start followed at once by a stop, and a second upload sent while the first is in flight, must both be dropped. A design that took them would tear the handshake or send a second load strobe with a changed value. Random runs of prescaler writes, ticks and flag writes check that the write gating and the set-wins-over-clear rules hold in every mix.

// File: rtl/rtc_ctrl_pkg.sv
package rtc_ctrl_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 2'd0,
        RA_PRESC = 2'd1,
        RA_STAGE = 2'd2,
        RA_SPARE = 2'd3
    } reg_addr_e;

    // control word bit positions (software-visible layout)
    localparam int B_RUN     = 0;
    localparam int B_STOP    = 1;
    localparam int B_ALM_ON  = 2;
    localparam int B_ALM_OFF = 3;
    localparam int B_ZERO    = 4;
    localparam int B_UPL     = 5;
    localparam int B_DNL     = 6;
    localparam int B_WK_CLR  = 8;
    localparam int B_WK_SET  = 9;
    localparam int B_UPD     = 10;

    typedef struct packed {
        logic start;
        logic stop;
        logic alm_on;
        logic alm_off;
        logic zero;
        logic upload;
        logic download;
        logic wk_clr;
        logic wk_set;
        logic upd_clr;
    } cmd_t;

    typedef struct packed {
        logic updated;
        logic wake;
        logic upl_busy;
        logic alarm;
        logic running;
    } stat_t;

    function automatic cmd_t decode_cmd(input logic [BUS_W-1:0] w, input logic sel);
        cmd_t c;
        c.start    = sel & w[B_RUN];
        c.stop     = sel & w[B_STOP];
        c.alm_on   = sel & w[B_ALM_ON];
        c.alm_off  = sel & w[B_ALM_OFF];
        c.zero     = sel & w[B_ZERO];
        c.upload   = sel & w[B_UPL];
        c.download = sel & w[B_DNL];
        c.wk_clr   = sel & w[B_WK_CLR];
        c.wk_set   = sel & w[B_WK_SET];
        c.upd_clr  = sel & w[B_UPD];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] pack_ctrl(input stat_t s);
        logic [BUS_W-1:0] r;
        r          = '0;
        r[B_RUN]   = s.running;
        r[B_ALM_ON] = s.alarm;
        r[B_UPL]   = s.upl_busy;
        r[B_WK_CLR] = s.wake;
        r[B_UPD]   = s.updated;
        return r;
    endfunction

endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rtc_xchan.sv
module rtc_xchan #(
    parameter int              DATA_W = 1,
    parameter int              STAGES = 2,
    parameter logic [DATA_W-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] hold_o,
    input  logic              cclk,
    input  logic              crst,
    output logic              c_stb_o,
    output logic [DATA_W-1:0] c_data_o
);
    logic req_t;
    logic ack_s;
    logic creq_s;
    logic cseen;
    logic accept;

    assign busy_o = req_t ^ ack_s;
    assign accept = go & ~busy_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_t  <= 1'b0;
            hold_o <= INIT;
        end else if (accept) begin
            req_t  <= ~req_t;
            hold_o <= data_i;
        end
    end

    rtc_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
        .clk(cclk), .rst(crst), .d(req_t), .q(creq_s)
    );

    always_ff @(posedge cclk) begin
        if (crst) begin
            cseen    <= 1'b0;
            c_stb_o  <= 1'b0;
            c_data_o <= INIT;
        end else begin
            cseen   <= creq_s;
            c_stb_o <= creq_s ^ cseen;
            if (creq_s ^ cseen) c_data_o <= hold_o;
        end
    end

    rtc_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
        .clk(clk), .rst(rst), .d(cseen), .q(ack_s)
    );

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy_o);  // R10
    AST_PENDING_DROP: assert property (@(posedge clk) disable iff (rst)
        (go && busy_o) |=> $stable(hold_o));  // R10
    AST_STB_SINGLE: assert property (@(posedge cclk) disable iff (crst)
        c_stb_o |=> !c_stb_o);  // R4
endmodule

// File: rtl/rtc_evt.sv
module rtc_evt #(
    parameter int STAGES = 2
) (
    input  logic cclk,
    input  logic crst,
    input  logic ev,
    input  logic clk,
    input  logic rst,
    output logic pulse_o
);
    logic tog;
    logic tog_s;
    logic tog_d;

    always_ff @(posedge cclk) begin
        if (crst) tog <= 1'b0;
        else if (ev) tog <= ~tog;
    end

    rtc_sync #(.W(1), .STAGES(STAGES)) u_ev_sync (
        .clk(clk), .rst(rst), .d(tog), .q(tog_s)
    );

    always_ff @(posedge clk) begin
        if (rst) tog_d <= 1'b0;
        else     tog_d <= tog_s;
    end

    assign pulse_o = tog_s ^ tog_d;
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
    import rtc_ctrl_pkg::*;
#(
    parameter int                 PRESC_W   = 16,
    parameter int                 TIME_W    = 32,
    parameter logic [PRESC_W-1:0] PRESC_RST = 16'h7FFF,
    parameter int                 STAGES    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic [PRESC_W-1:0] prescale_o,
    output logic               wakeup_o,
    input  logic               cnt_clk,
    input  logic               cnt_rst,
    input  logic [TIME_W-1:0]  cnt_value,
    input  logic               cnt_tick,
    input  logic               cnt_wake,
    output logic               cnt_run,
    output logic               cnt_alarm_en,
    output logic               cnt_load_stb,
    output logic [TIME_W-1:0]  cnt_load_val
);
    reg_addr_e         addr;
    cmd_t              cmd;
    stat_t             st;
    logic              run_go, run_busy, run_hold, run_next;
    logic              alm_go, alm_busy, alm_hold, alm_next;
    logic              upl_go, upl_busy;
    logic [TIME_W-1:0] upl_hold, upl_next;
    logic              run_stb, alm_stb;
    logic              tick_p, wake_p;
    logic [TIME_W-1:0] stage;
    logic              updated, wake;
    logic              running;

    assign addr = reg_addr_e'(bus_addr);
    assign cmd  = decode_cmd(bus_wdata, bus_we && (addr == RA_CTRL));

    // run channel: status reads requested level OR in-flight
    assign run_next = cmd.start & ~cmd.stop;
    assign run_go   = (cmd.start | cmd.stop) & ~run_busy;
    assign running  = run_hold | run_busy;

    rtc_xchan #(.DATA_W(1), .STAGES(STAGES)) u_run (
        .clk(clk), .rst(rst), .go(run_go), .data_i(run_next),
        .busy_o(run_busy), .hold_o(run_hold),
        .cclk(cnt_clk), .crst(cnt_rst), .c_stb_o(run_stb), .c_data_o(cnt_run)
    );

    // alarm channel
    assign alm_next = cmd.alm_on & ~cmd.alm_off;
    assign alm_go   = (cmd.alm_on | cmd.alm_off) & ~alm_busy;

    rtc_xchan #(.DATA_W(1), .STAGES(STAGES)) u_alm (
        .clk(clk), .rst(rst), .go(alm_go), .data_i(alm_next),
        .busy_o(alm_busy), .hold_o(alm_hold),
        .cclk(cnt_clk), .crst(cnt_rst), .c_stb_o(alm_stb), .c_data_o(cnt_alarm_en)
    );

    // upload channel: clear sends zero, upload sends staging word
    assign upl_go   = (cmd.zero | cmd.upload) & ~upl_busy;
    assign upl_next = cmd.zero ? '0 : stage;

    rtc_xchan #(.DATA_W(TIME_W), .STAGES(STAGES)) u_upl (
        .clk(clk), .rst(rst), .go(upl_go), .data_i(upl_next),
        .busy_o(upl_busy), .hold_o(upl_hold),
        .cclk(cnt_clk), .crst(cnt_rst), .c_stb_o(cnt_load_stb), .c_data_o(cnt_load_val)
    );

    rtc_evt #(.STAGES(STAGES)) u_tick (
        .cclk(cnt_clk), .crst(cnt_rst), .ev(cnt_tick),
        .clk(clk), .rst(rst), .pulse_o(tick_p)
    );

    rtc_evt #(.STAGES(STAGES)) u_wake (
        .cclk(cnt_clk), .crst(cnt_rst), .ev(cnt_wake),
        .clk(clk), .rst(rst), .pulse_o(wake_p)
    );

    // staging word: clear > download > software write
    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else if (cmd.zero && !upl_busy) begin
            stage <= '0;
        end else if (cmd.download) begin
            stage <= cnt_value;
        end else if (bus_we && addr == RA_STAGE) begin
            stage <= bus_wdata[TIME_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prescale_o <= PRESC_RST;
        end else if (bus_we && addr == RA_PRESC && !running) begin
            prescale_o <= bus_wdata[PRESC_W-1:0];
        end
    end

    // event flags: set wins over clear
    always_ff @(posedge clk) begin
        if (rst) begin
            updated <= 1'b0;
            wake    <= 1'b0;
        end else begin
            if (tick_p)           updated <= 1'b1;
            else if (cmd.upd_clr) updated <= 1'b0;
            if (wake_p || cmd.wk_set) wake <= 1'b1;
            else if (cmd.wk_clr)      wake <= 1'b0;
        end
    end

    assign wakeup_o = wake;

    always_comb begin
        st.updated  = updated;
        st.wake     = wake;
        st.upl_busy = upl_busy;
        st.alarm    = alm_hold | alm_busy;
        st.running  = running;
        case (addr)
            RA_CTRL:  bus_rdata = pack_ctrl(st);
            RA_PRESC: bus_rdata = BUS_W'(prescale_o);
            RA_STAGE: bus_rdata = BUS_W'(stage);
            default:  bus_rdata = '0;
        endcase
    end

    AST_STOP_HELD: assert property (@(posedge clk) disable iff (rst)
        (cmd.stop && !run_busy && running) |=> running);  // R2
    AST_PRESC_LOCK: assert property (@(posedge clk) disable iff (rst)
        (bus_we && addr == RA_PRESC && running) |=> $stable(prescale_o));  // R3
    AST_DNL_COPY: assert property (@(posedge clk) disable iff (rst)
        (cmd.download && !(cmd.zero && !upl_busy)) |=> (stage == $past(cnt_value)));  // R6
    AST_ALM_FAST: assert property (@(posedge clk) disable iff (rst)
        (cmd.alm_on && !cmd.alm_off && !alm_busy) |=> st.alarm);  // R7
    AST_UPD_CLR: assert property (@(posedge clk) disable iff (rst)
        (cmd.upd_clr && !tick_p) |=> !updated);  // R8
    AST_WAKE_SET: assert property (@(posedge clk) disable iff (rst)
        cmd.wk_set |=> wakeup_o);  // R9
    AST_RUN_STB: assert property (@(posedge cnt_clk) disable iff (cnt_rst)
        run_stb |=> !run_stb);  // R2
    AST_ALM_STB: assert property (@(posedge cnt_clk) disable iff (cnt_rst)
        alm_stb |=> !alm_stb);  // R7
    AST_UPL_HOLD: assert property (@(posedge clk) disable iff (rst)
        upl_busy |=> (upl_busy ? $stable(upl_hold) : 1'b1));  // R4
endmodule

// File: tb/tb_rtc_ctrl_regs.sv
module tb_rtc_ctrl_regs;
    localparam int CLK_PERIOD  = 10;
    localparam int CCLK_PERIOD = 26;
    localparam int SETTLE      = 40;

    logic        clk = 0, rst = 1, cnt_clk = 0, cnt_rst = 1;
    logic [1:0]  bus_addr = 0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [15:0] prescale_o;
    logic        wakeup_o;
    logic [31:0] cnt_value = 0;
    logic        cnt_tick = 0, cnt_wake = 0;
    logic        cnt_run, cnt_alarm_en, cnt_load_stb;
    logic [31:0] cnt_load_val;

    int checks = 0, errors = 0, loads = 0;
    logic [31:0] last_load = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(CCLK_PERIOD/2) cnt_clk = ~cnt_clk;

    rtc_ctrl_regs dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prescale_o(prescale_o),
        .wakeup_o(wakeup_o), .cnt_clk(cnt_clk), .cnt_rst(cnt_rst),
        .cnt_value(cnt_value), .cnt_tick(cnt_tick), .cnt_wake(cnt_wake),
        .cnt_run(cnt_run), .cnt_alarm_en(cnt_alarm_en),
        .cnt_load_stb(cnt_load_stb), .cnt_load_val(cnt_load_val)
    );

    always @(negedge cnt_clk) if (!cnt_rst && cnt_load_stb) begin
        loads++;
        last_load = cnt_load_val;
    end

    function automatic logic [31:0] ctrl_model(bit run, bit alm, bit upl, bit wk, bit upd);
        logic [31:0] r = '0;
        r[0] = run; r[2] = alm; r[5] = upl; r[8] = wk; r[10] = upd;
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_we = 0; bus_wdata = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic poll_bit(int b, logic v, string req);
        logic [31:0] d;
        for (int i = 0; i < 80; i++) begin
            rd(0, d);
            if (d[b] === v) break;
            @(negedge clk);
        end
        rd(0, d);
        chk(req, 32'(d[b]), 32'(v));
    endtask

    task automatic cpulse(bit tick);
        @(negedge cnt_clk);
        if (tick) cnt_tick = 1; else cnt_wake = 1;
        @(negedge cnt_clk);
        cnt_tick = 0; cnt_wake = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int unsigned seed;
        bit m_run, m_upd, m_wk;
        logic [15:0] m_presc;
        int l0;
        seed = $urandom(32'd2024);

        repeat (4) @(negedge cnt_clk);
        @(negedge clk); rst = 0; cnt_rst = 0;
        @(negedge clk);

        // R1 / R11 reset state
        rd(0, d); chk("R1 ctrl", d, 0);
        rd(1, d); chk("R1 presc", d, 32'h7FFF);
        rd(2, d); chk("R1 stage", d, 0);
        rd(3, d); chk("R11 spare", d, 0);
        chk("R1 outs", {29'd0, cnt_run, cnt_alarm_en, wakeup_o}, 0);

        // R3 prescaler writable while stopped
        wr(1, 32'hFFFF_1234); rd(1, d); chk("R3 stopped write", d, 32'h1234);

        // R2 start
        wr(0, 32'h1); rd(0, d); chk("R2 start fast", 32'(d[0]), 1);
        idle(SETTLE); chk("R2 cnt_run up", 32'(cnt_run), 1);

        // R3 write ignored while running
        wr(1, 32'h55); rd(1, d); chk("R3 running write", d, 32'h1234);

        // R2 stop held until acknowledged
        wr(0, 32'h2); rd(0, d); chk("R2 stop pending", 32'(d[0]), 1);
        chk("R2 cnt_run still", 32'(cnt_run), 1);
        wr(1, 32'h77); rd(1, d); chk("R3 stop pending write", d, 32'h1234);
        poll_bit(0, 0, "R2 stop done");
        chk("R2 cnt_run down", 32'(cnt_run), 0);

        // R10 stop during pending start dropped
        wr(0, 32'h1); wr(0, 32'h2); idle(SETTLE);
        rd(0, d); chk("R10 stop dropped", 32'(d[0]), 1);
        chk("R10 cnt_run", 32'(cnt_run), 1);
        wr(0, 32'h2); poll_bit(0, 0, "R2 stop again");

        // R11 zero write
        wr(0, 32'h0); idle(SETTLE); rd(0, d); chk("R11 zero write", d, 0);
        rd(2, d); chk("R11 zero stage", d, 0);

        // R4 upload, R10 second upload dropped
        wr(2, 32'hA5A5_1234); l0 = loads;
        wr(0, 32'h20); rd(0, d); chk("R4 upload pending", 32'(d[5]), 1);
        wr(2, 32'hDEAD_BEEF); wr(0, 32'h20);
        poll_bit(5, 0, "R4 upload done"); idle(SETTLE);
        chk("R10 one load", 32'(loads - l0), 1);
        chk("R4 load value", last_load, 32'hA5A5_1234);

        // R5 clear and upload
        l0 = loads;
        wr(0, 32'h10); rd(0, d); chk("R5 busy", 32'(d[5]), 1);
        rd(2, d); chk("R5 stage zero", d, 0);
        poll_bit(5, 0, "R5 done"); idle(4);
        chk("R5 load count", 32'(loads - l0), 1);
        chk("R5 load zero", last_load, 0);

        // R6 download
        cnt_value = 32'h0BAD_F00D;
        wr(0, 32'h40); rd(2, d); chk("R6 download", d, 32'h0BAD_F00D);

        // R7 alarm
        wr(0, 32'h4); rd(0, d); chk("R7 alarm on fast", 32'(d[2]), 1);
        idle(SETTLE); chk("R7 cnt alarm", 32'(cnt_alarm_en), 1);
        wr(0, 32'h8); rd(0, d); chk("R7 off pending", 32'(d[2]), 1);
        chk("R7 cnt alarm still", 32'(cnt_alarm_en), 1);
        poll_bit(2, 0, "R7 off done");
        chk("R7 cnt alarm down", 32'(cnt_alarm_en), 0);

        // R8 updated
        cpulse(1); poll_bit(10, 1, "R8 tick sets");
        wr(0, 32'h400); rd(0, d); chk("R8 clear", 32'(d[10]), 0);

        // R9 wakeup
        wr(0, 32'h200); rd(0, d); chk("R9 set", 32'(d[8]), 1);
        chk("R9 pin", 32'(wakeup_o), 1);
        wr(0, 32'h300); rd(0, d); chk("R9 set wins", 32'(d[8]), 1);
        wr(0, 32'h100); rd(0, d); chk("R9 clear", 32'(d[8]), 0);
        chk("R9 pin clear", 32'(wakeup_o), 0);
        cpulse(0); poll_bit(8, 1, "R9 event sets");
        wr(0, 32'h100);

        // random mix
        m_run = 0; m_upd = 0; m_wk = 0; m_presc = 16'h1234;
        for (int it = 0; it < 250; it++) begin
            int unsigned op = $urandom_range(0, 6);
            logic [31:0] v = $urandom;
            case (op)
                0: begin wr(1, v); if (!m_run) m_presc = v[15:0]; end
                1: begin wr(0, 32'h1); m_run = 1; idle(SETTLE); end
                2: begin wr(0, 32'h2); m_run = 0; idle(SETTLE); end
                3: begin cpulse(1); idle(10); m_upd = 1; end
                4: begin wr(0, 32'h400); m_upd = 0; end
                5: begin wr(0, 32'h200); m_wk = 1; end
                default: begin wr(0, 32'h100); m_wk = 0; end
            endcase
            rd(1, d); chk("R3 random presc", d, 32'(m_presc));
            rd(0, d); chk("R8 R9 random ctrl", d, ctrl_model(m_run, 0, 0, m_wk, m_upd));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule